// File: doc/BRIEF.md
# Hash Engine Control Register Block

This block is the register front end of a hash offload engine. Software on a simple 32-bit word-indexed register bus programs a source address, a digest destination address, a source length and a command word. A command write is decoded into an algorithm code and mode flags. When the selection is legal and the engine is idle, the block fires a single-cycle start pulse towards the hashing datapath, which sits outside this block.

The datapath answers with a done pulse. The block then sets a completion flag in its status word, whether or not interrupts were requested, and raises its interrupt line only when the command asked for it. Software acknowledges by writing the completion bit back to the status word, which clears both the flag and the line. While an operation is in flight, the status word reports busy and further command writes are dropped.

Top module: `hash_ctl_regs`

## Requirements
- R1: After reset every register reads zero, and eng_start, irq and the busy bit (status bit 0) are low.
- R2: The source address (word 8) keeps only bits [ADDR_W-1:0]. The destination address (word 9) keeps the same bits but with bits [2:0] forced to zero. The source length (word 11) keeps bits [27:0]. Each reads back its masked value.
- R3: The primary selector is command bits [6:4], and with bits [12:10] equal to 000 it decodes to the following eng_algo codes: 000 gives MD5 (code 0), 010 gives SHA-1 (1), 100 gives SHA-224 (2) and 101 gives SHA-256 (3).
- R4: A primary selector of 110 picks the wide family, and bits [12:10] then pick the variant: 000 gives SHA-512 (code 4), 001 gives SHA-384 (5) and 010 gives SHA-512/256 (6).
- R5: Any other combination of bits [6:4] and [12:10] is invalid. The masked command is stored, but no start pulse is issued and busy stays low.
- R6: A valid command write (word 12) to an idle block stores the command ANDed with CMD_MASK. eng_start is then high for exactly the one cycle after the write edge, and status bit 0 reads 1 until done. eng_sg reflects command bit 18.
- R7: While busy, command writes are ignored: the stored command is unchanged and no start pulse is issued.
- R8: On eng_done while busy, busy clears and status bit 9 sets, regardless of interrupt enable. irq rises only if stored command bit 9 is set.
- R9: A status write (word 7) with bit 9 set clears status bit 9 and irq. A status write with bit 9 clear changes neither.
- R10: Word indices at or above REG_WORDS read zero, and writes to them change no register. Unassigned indices below REG_WORDS also read zero.
- R11: eng_done while idle has no effect on status or irq.
- R12: The cipher command word (word 4) stores its written value and reads it back, and writing it starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_widx | input | BUS_AW | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when bus_rd is low |
| eng_start | output | 1 | One-cycle start pulse to the datapath |
| eng_algo | output | 3 | Decoded algorithm code |
| eng_sg | output | 1 | Scatter-gather request flag |
| eng_hmac | output | 2 | Keyed-hash mode field |
| eng_chain | output | 2 | Cascaded mode field |
| eng_src | output | 32 | Source address |
| eng_dst | output | 32 | Destination address |
| eng_len | output | 32 | Source length |
| eng_done | input | 1 | Completion pulse from the datapath |
| irq | output | 1 | Completion interrupt |

## Verification
The bench builds the block with ADDR_W set to 30 and the default CMD_MASK and REG_WORDS. The narrower address width makes the source and destination truncation visible at bit 30 and bit 31. The default command mask keeps both algorithm fields and the scatter-gather bit writable, so every legal and illegal selector pair can be reached. With REG_WORDS at 16, a write to word 28 hits the same low index bits as the command word, which exposes any aliasing outside the window.

// File: rtl/hash_ctl_pkg.sv
package hash_ctl_pkg;

  typedef enum logic [2:0] {
    ALG_MD5     = 3'd0,
    ALG_SHA1    = 3'd1,
    ALG_SHA224  = 3'd2,
    ALG_SHA256  = 3'd3,
    ALG_SHA512  = 3'd4,
    ALG_SHA384  = 3'd5,
    ALG_S512T   = 3'd6
  } alg_e;

  // word indices of the register window
  localparam int unsigned W_CIPHER = 4;
  localparam int unsigned W_STAT   = 7;
  localparam int unsigned W_SRC    = 8;
  localparam int unsigned W_DST    = 9;
  localparam int unsigned W_LEN    = 11;
  localparam int unsigned W_CMD    = 12;

  localparam int unsigned ST_BUSY  = 0;
  localparam int unsigned ST_DONE  = 9;
  localparam int unsigned CM_IRQ   = 9;
  localparam int unsigned CM_SG    = 18;
  localparam int unsigned LEN_W    = 28;

endpackage

// File: rtl/hash_cmd_decode.sv
module hash_cmd_decode
  import hash_ctl_pkg::*;
(
  input  logic [2:0] prim_i,
  input  logic [2:0] var_i,
  output logic       valid_o,
  output alg_e       alg_o
);

  always_comb begin
    valid_o = 1'b1;
    alg_o   = ALG_MD5;
    if (prim_i == 3'b110) begin
      case (var_i)
        3'b000:  alg_o = ALG_SHA512;
        3'b001:  alg_o = ALG_SHA384;
        3'b010:  alg_o = ALG_S512T;
        default: valid_o = 1'b0;
      endcase
    end else if (var_i != 3'b000) begin
      valid_o = 1'b0;
    end else begin
      case (prim_i)
        3'b000:  alg_o = ALG_MD5;
        3'b010:  alg_o = ALG_SHA1;
        3'b100:  alg_o = ALG_SHA224;
        3'b101:  alg_o = ALG_SHA256;
        default: valid_o = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/hash_ctl_seq.sv
module hash_ctl_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic eng_done_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic busy_o,
  output logic start_o,
  output logic done_o,
  output logic irq_o
);

  logic busy_q, busy_d, start_q, start_d, done_q, done_d, irq_q, irq_d;
  logic finish;

  assign finish = busy_q && eng_done_i;

  always_comb begin
    busy_d  = busy_q;
    start_d = 1'b0;
    done_d  = done_q;
    irq_d   = irq_q;
    if (launch_i && !busy_q) begin
      busy_d  = 1'b1;
      start_d = 1'b1;
    end else if (finish) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      irq_d  = irq_q | irq_en_i;
    end
    if (clr_i && !finish) begin
      done_d = 1'b0;
      irq_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
    end
  end

  assign busy_o  = busy_q;
  assign start_o = start_q;
  assign done_o  = done_q;
  assign irq_o   = irq_q;

  // R6
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  // R6
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> busy_q);
  // R8
  done_from_engine_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(eng_done_i && busy_q));
  // R8
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> done_q);
  // R11
  busy_ends_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(eng_done_i));

endmodule

// File: rtl/hash_ctl_regs.sv
module hash_ctl_regs
  import hash_ctl_pkg::*;
#(
  parameter int unsigned BUS_AW    = 10,
  parameter int unsigned REG_WORDS = 16,
  parameter int unsigned ADDR_W    = 31,
  parameter logic [31:0] CMD_MASK  = 32'h0014_7FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_widx,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_start,
  output logic [2:0]        eng_algo,
  output logic              eng_sg,
  output logic [1:0]        eng_hmac,
  output logic [1:0]        eng_chain,
  output logic [31:0]       eng_src,
  output logic [31:0]       eng_dst,
  output logic [31:0]       eng_len,
  input  logic              eng_done,
  output logic              irq
);

  localparam logic [31:0] SRC_MASK = 32'((64'd1 << ADDR_W) - 64'd1);
  localparam logic [31:0] DST_MASK = SRC_MASK & ~32'h7;
  localparam logic [31:0] LEN_MASK = 32'((64'd1 << LEN_W) - 64'd1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  logic in_win;
  logic wr_cipher, wr_stat, wr_src, wr_dst, wr_len, wr_cmd;
  assign in_win    = 32'(bus_widx) < REG_WORDS;
  assign wr_cipher = bus_wr && in_win && (32'(bus_widx) == W_CIPHER);
  assign wr_stat   = bus_wr && in_win && (32'(bus_widx) == W_STAT);
  assign wr_src    = bus_wr && in_win && (32'(bus_widx) == W_SRC);
  assign wr_dst    = bus_wr && in_win && (32'(bus_widx) == W_DST);
  assign wr_len    = bus_wr && in_win && (32'(bus_widx) == W_LEN);
  assign wr_cmd    = bus_wr && in_win && (32'(bus_widx) == W_CMD);

  logic [31:0] cipher_q, src_q, dst_q, len_q, cmd_q;
  logic [31:0] cipher_d, src_d, dst_d, len_d, cmd_d;
  logic [31:0] cmd_new;
  logic        busy, done_flag, new_ok, cur_ok, accept;
  alg_e        new_alg, cur_alg;

  assign cmd_new = bus_wdata & CMD_MASK;

  hash_cmd_decode dec_new_i (
    .prim_i (cmd_new[6:4]),
    .var_i  (cmd_new[12:10]),
    .valid_o(new_ok),
    .alg_o  (new_alg)
  );

  hash_cmd_decode dec_cur_i (
    .prim_i (cmd_q[6:4]),
    .var_i  (cmd_q[12:10]),
    .valid_o(cur_ok),
    .alg_o  (cur_alg)
  );

  assign accept = wr_cmd && !busy;

  always_comb begin
    cipher_d = cipher_q;
    src_d    = src_q;
    dst_d    = dst_q;
    len_d    = len_q;
    cmd_d    = cmd_q;
    if (wr_cipher) cipher_d = bus_wdata;
    if (wr_src)    src_d    = bus_wdata & SRC_MASK;
    if (wr_dst)    dst_d    = bus_wdata & DST_MASK;
    if (wr_len)    len_d    = bus_wdata & LEN_MASK;
    if (accept)    cmd_d    = cmd_new;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      cipher_q <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      len_q    <= '0;
      cmd_q    <= '0;
    end else begin
      cipher_q <= cipher_d;
      src_q    <= src_d;
      dst_q    <= dst_d;
      len_q    <= len_d;
      cmd_q    <= cmd_d;
    end
  end

  hash_ctl_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_q),
    .launch_i  (accept && new_ok),
    .eng_done_i(eng_done),
    .clr_i     (wr_stat && bus_wdata[ST_DONE]),
    .irq_en_i  (cmd_q[CM_IRQ]),
    .busy_o    (busy),
    .start_o   (eng_start),
    .done_o    (done_flag),
    .irq_o     (irq)
  );

  logic [31:0] stat_word;
  always_comb begin
    stat_word          = '0;
    stat_word[ST_BUSY] = busy;
    stat_word[ST_DONE] = done_flag;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && in_win) begin
      case (32'(bus_widx))
        W_CIPHER: bus_rdata = cipher_q;
        W_STAT:   bus_rdata = stat_word;
        W_SRC:    bus_rdata = src_q;
        W_DST:    bus_rdata = dst_q;
        W_LEN:    bus_rdata = len_q;
        W_CMD:    bus_rdata = cmd_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assign eng_algo  = cur_alg;
  assign eng_sg    = cmd_q[CM_SG];
  assign eng_hmac  = cmd_q[8:7];
  assign eng_chain = cmd_q[1:0];
  assign eng_src   = src_q;
  assign eng_dst   = dst_q;
  assign eng_len   = len_q;

  // R5
  start_needs_legal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_q)
    eng_start |-> cur_ok);
  // R7
  busy_cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (busy && bus_wr) |=> $stable(cmd_q));
  // R10
  outside_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_wr && !in_win) |=> ($stable(cmd_q) && $stable(src_q) && $stable(dst_q)
                             && $stable(len_q) && $stable(cipher_q)));
  // R2
  dst_aligned_chk: assert property (@(posedge clk) disable iff (!rst_q)
    dst_q[2:0] == 3'b000);

endmodule

// File: tb/hash_ctl_regs_tb_top.sv
module hash_ctl_regs_tb_top;

  localparam int unsigned AW   = 10;
  localparam int unsigned AWID = 30;
  localparam logic [31:0] CMSK = 32'h0014_7FFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_widx = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_start, eng_sg, irq;
  logic [2:0]  eng_algo;
  logic [1:0]  eng_hmac, eng_chain;
  logic [31:0] eng_src, eng_dst, eng_len;
  logic        eng_done = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #4 clk = ~clk;

  hash_ctl_regs #(.BUS_AW(AW), .REG_WORDS(16), .ADDR_W(AWID), .CMD_MASK(CMSK)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start(eng_start), .eng_algo(eng_algo), .eng_sg(eng_sg),
    .eng_hmac(eng_hmac), .eng_chain(eng_chain), .eng_src(eng_src),
    .eng_dst(eng_dst), .eng_len(eng_len), .eng_done(eng_done), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_widx = AW'(idx); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [31:0] d);
    bus_widx = AW'(idx); bus_rd = 1'b1;
    #1;
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  // expected decode from the requirement tables (R3, R4, R5)
  function automatic bit exp_dec(input logic [31:0] c, output logic [2:0] code);
    logic [2:0] p, v;
    p = c[6:4]; v = c[12:10]; code = 3'd0;
    if (p == 3'b110) begin
      if (v == 3'd0) begin code = 3'd4; return 1'b1; end
      if (v == 3'd1) begin code = 3'd5; return 1'b1; end
      if (v == 3'd2) begin code = 3'd6; return 1'b1; end
      return 1'b0;
    end
    if (v != 3'd0) return 1'b0;
    case (p)
      3'b000: begin code = 3'd0; return 1'b1; end
      3'b010: begin code = 3'd1; return 1'b1; end
      3'b100: begin code = 3'd2; return 1'b1; end
      3'b101: begin code = 3'd3; return 1'b1; end
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_cmd(input logic [31:0] c, input int gap);
    logic [31:0] m, r;
    logic [2:0]  code;
    bit ok;
    m  = c & CMSK;
    ok = exp_dec(m, code);
    wr(12, c);
    chk(eng_start == ok, ok ? "R6 start" : "R5 no start", 32'(eng_start), 32'(ok));
    rd(12, r);
    chk(r == m, "R6 cmd stored", r, m);
    if (!ok) begin
      rd(7, r);
      chk(r[0] == 1'b0, "R5 busy low", r, 32'h0);
      return;
    end
    chk(32'(eng_algo) == 32'(code), (m[6:4] == 3'b110) ? "R4 algo" : "R3 algo",
        32'(eng_algo), 32'(code));
    chk(eng_sg == m[18], "R6 sg flag", 32'(eng_sg), 32'(m[18]));
    @(negedge clk);
    chk(eng_start == 1'b0, "R6 pulse width", 32'(eng_start), 32'h0);
    rd(7, r);
    chk(r == 32'h1, "R6 busy", r, 32'h1);
    for (int k = 0; k < gap; k++) @(negedge clk);
    pulse_done();
    rd(7, r);
    chk(r == 32'h200, "R8 done flag", r, 32'h200);
    chk(irq == m[9], "R8 irq", 32'(irq), 32'(m[9]));
    wr(7, 32'h200);
    rd(7, r);
    chk(r == 32'h0 && irq == 1'b0, "R9 clear", {r[30:0], irq}, 32'h0);
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r, s;
    void'($urandom(32'h5EED_0042));
    #1;
    rd(12, r);
    chk(r == 0 && eng_start == 0 && irq == 0, "R1 in reset", r, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rd(i, r);
      chk(r == 32'h0, "R1 reset value", r, 32'h0);
    end
    chk(eng_start == 0 && irq == 0, "R1 outputs", {30'h0, eng_start, irq}, 32'h0);

    // R2 masks, ADDR_W = 30
    wr(8, 32'hFFFF_FFFF); rd(8, r); chk(r == 32'h3FFF_FFFF, "R2 src", r, 32'h3FFF_FFFF);
    wr(9, 32'hFFFF_FFFF); rd(9, r); chk(r == 32'h3FFF_FFF8, "R2 dst", r, 32'h3FFF_FFF8);
    wr(11, 32'hFFFF_FFFF); rd(11, r); chk(r == 32'h0FFF_FFFF, "R2 len", r, 32'h0FFF_FFFF);
    chk(eng_dst == 32'h3FFF_FFF8, "R2 dst port", eng_dst, 32'h3FFF_FFF8);

    // R12 cipher word
    wr(4, 32'hA5A5_1234);
    chk(eng_start == 0, "R12 no start", 32'(eng_start), 32'h0);
    rd(4, r); chk(r == 32'hA5A5_1234, "R12 readback", r, 32'hA5A5_1234);

    // directed decode: all R3 and R4 codes, and invalid ones for R5
    run_cmd(32'h0000_0000, 0);
    run_cmd(32'h0000_0220, 1);
    run_cmd(32'h0000_0040, 0);
    run_cmd(32'h0000_0250, 2);
    run_cmd(32'h0004_0060, 0);
    run_cmd(32'h0000_0460, 0);
    run_cmd(32'h0000_0860, 1);
    run_cmd(32'h0000_0C60, 0);
    run_cmd(32'h0000_0070, 0);
    run_cmd(32'h0000_0410, 0);

    // R7 writes while busy
    wr(12, 32'h0000_0020);
    wr(12, 32'h0000_0050);
    chk(eng_start == 0, "R7 no restart", 32'(eng_start), 32'h0);
    rd(12, r); chk(r == 32'h20, "R7 cmd kept", r, 32'h20);
    pulse_done();
    rd(7, r); chk(r == 32'h200, "R8 done w/o irq en", r, 32'h200);
    chk(irq == 0, "R8 irq off", 32'(irq), 32'h0);
    // R9 write without bit 9
    wr(7, 32'hFFFF_FDFF);
    rd(7, r); chk(r == 32'h200, "R9 no clear", r, 32'h200);
    wr(7, 32'h200);
    // R11 done while idle
    pulse_done();
    rd(7, r); chk(r == 0 && irq == 0, "R11 idle done", r, 32'h0);

    // R10 outside window and unassigned words
    rd(12, s);
    wr(28, 32'h0000_0220);
    chk(eng_start == 0, "R10 no start", 32'(eng_start), 32'h0);
    rd(12, r); chk(r == s, "R10 no alias", r, s);
    rd(28, r); chk(r == 0, "R10 outside read", r, 32'h0);
    wr(5, 32'hDEAD_BEEF);
    rd(5, r); chk(r == 0, "R10 unassigned read", r, 32'h0);

    // constrained random commands
    for (int n = 0; n < 300; n++) begin
      logic [31:0] c;
      c = $urandom();
      if (n % 2 == 0) begin
        c[6:4]   = 3'($urandom_range(0, 7));
        c[12:10] = 3'($urandom_range(0, 2));
      end
      run_cmd(c, int'($urandom_range(0, 3)));
      if (n % 25 == 0) begin
        logic [31:0] a;
        a = $urandom();
        wr(8, a); rd(8, r);
        chk(r == (a & 32'h3FFF_FFFF), "R2 src random", r, a & 32'h3FFF_FFFF);
      end
    end

    ended = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule